// File: doc/BRIEF.md
# Memory fence ordering gate

This block sits beside a small in-order window of pending memory-related instructions and decides, every cycle, which of them may go ahead. A store or fence "going ahead" means it may commit; a load going ahead means it may take its value. The window holds `N` slots, slot 0 being the oldest. Each slot carries a descriptor: a valid bit, a finished bit, an instruction kind, an ordering annotation and four fence ordering bits. For each slot the gate raises a permit when no older unfinished instruction forbids it. It also raises a flag for fences whose ordering bits form an unsupported combination.

The rules come from the fence predecessor and successor bits, a separate total-store-order fence kind, and weak (RCpc) and strong (RCsc) acquire/release annotations. Older blockers are gathered with a prefix OR over the older slots, so every permit is combinational in the current descriptors. Each slot also has a two-state machine. A fence that is granted moves its slot from `SLOT_OPEN` to `SLOT_CLEARED` at the next edge. A cleared slot neither blocks younger slots nor receives a permit. The slot returns to `SLOT_OPEN` on the first edge at which its valid input is low. Reset puts every slot in `SLOT_OPEN`.

Encodings: kind 0 empty, 1 load, 2 store, 3 normal fence, 4 total-store-order fence, 5 branch; codes 6 and 7 are treated as empty. Annotation 0 plain, 1 acquire-RCpc, 2 acquire-RCsc, 3 release-RCpc, 4 release-RCsc, 5 acquire-release-RCsc; codes 6 and 7 are treated as plain. The fence bits of a slot are [3] older loads (PR), [2] older stores (PW), [1] younger loads (SR) and [0] younger stores (SW). An older instruction counts as a blocker only if its slot is valid, not finished and open.

Top module: `fence_order_gate`

## Requirements
- R1: A normal fence with bit 3 set gets no permit while any older load is unfinished. A normal fence with bit 2 set gets no permit while any older store is unfinished. Otherwise a legal normal fence is permitted.
- R2: A total-store-order fence gets no permit while any older load or store is unfinished.
- R3: A store gets no permit while any of the following older instructions is unfinished: a normal fence with bit 0 set, a total-store-order fence, a load with annotation 1, 2 or 5, a store with annotation 5, or a branch.
- R4: A store with annotation 3, 4 or 5 gets no permit while any older non-empty slot is unfinished.
- R5: A load gets no permit while an older normal fence with both bit 2 and bit 1 set is unfinished.
- R6: A load with annotation 5 gets no permit while any older non-empty slot is unfinished. A load with annotation 2 gets no permit while an older store with annotation 4 or 5 is unfinished. A load with annotation 1 ignores older release stores.
- R7: A live normal fence whose bits are not 1010, 0101, 1101, 1011 or 1111 raises its illegal flag and gets no permit.
- R8: A fence granted a permit is cleared at the next edge. While cleared, it has no permit and blocks nothing. It reopens after an edge at which its valid input is low.
- R9: Empty, branch, invalid and finished slots never get a permit. An open, unfinished load or store in slot 0 is always permitted.
- R10: While reset is active, no slot is cleared, and after reset every slot is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | N | Slot holds an instruction |
| slot_done | input | N | Instruction in the slot is finished |
| slot_kind | input | 3*N | Kind code per slot, slot i at [3i+2:3i] |
| slot_annot | input | 3*N | Annotation code per slot |
| slot_fbits | input | 4*N | Fence bits per slot, slot i at [4i+3:4i] |
| permit | output | N | Slot may commit or take its value |
| fence_illegal | output | N | Normal fence with unsupported bit combination |

## Verification
The hardest situation to reach from the ports is a cleared fence that still sits in the window with its valid bit high. The younger slots must then be released by the clearing alone, not by the finished bit, and a later refill of the same slot must behave like a fresh instruction. Directed sequences hold an unfinished fence with younger loads and stores behind it across several edges. They then drop the valid bit for one cycle and load a new fence into the slot. The random stimulus keeps slots valid three times in four, so cleared fences stay in the window and are met by changing younger traffic.

// File: rtl/fence_gate_pkg.sv
package fence_gate_pkg;

    localparam int KIND_W  = 3;
    localparam int ANNOT_W = 3;
    localparam int FBITS_W = 4;

    localparam logic [KIND_W-1:0] K_EMPTY  = 3'd0;
    localparam logic [KIND_W-1:0] K_LOAD   = 3'd1;
    localparam logic [KIND_W-1:0] K_STORE  = 3'd2;
    localparam logic [KIND_W-1:0] K_FENCE  = 3'd3;
    localparam logic [KIND_W-1:0] K_TSO    = 3'd4;
    localparam logic [KIND_W-1:0] K_BRANCH = 3'd5;

    localparam logic [ANNOT_W-1:0] A_PLAIN  = 3'd0;
    localparam logic [ANNOT_W-1:0] A_ACQ_PC = 3'd1;
    localparam logic [ANNOT_W-1:0] A_ACQ_SC = 3'd2;
    localparam logic [ANNOT_W-1:0] A_REL_PC = 3'd3;
    localparam logic [ANNOT_W-1:0] A_REL_SC = 3'd4;
    localparam logic [ANNOT_W-1:0] A_AQRL   = 3'd5;

    // fence bit positions: older loads, older stores, younger loads, younger stores
    localparam int FB_OLD_LD = 3;
    localparam int FB_OLD_ST = 2;
    localparam int FB_NEW_LD = 1;
    localparam int FB_NEW_ST = 0;

    // Outstanding-blocker attributes a slot exposes to younger slots
    typedef struct packed {
        logic ld;       // unfinished load
        logic st;       // unfinished store
        logic any;      // unfinished non-empty instruction
        logic f_sw;     // normal fence ordering younger stores
        logic tso;      // total-store-order fence
        logic acq_ld;   // acquire load (any strength)
        logic aqrl_st;  // acquire-release store
        logic br;       // unresolved branch
        logic pw_sr;    // fence ordering older stores before younger loads
        logic rcsc_rl;  // strong release store
    } blk_t;

    function automatic logic fbits_legal(input logic [FBITS_W-1:0] b);
        return (b == 4'b1010) || (b == 4'b0101) || (b == 4'b1101) ||
               (b == 4'b1011) || (b == 4'b1111);
    endfunction

endpackage

// File: rtl/gate_slot_fsm.sv
module gate_slot_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic grant_fence,
    output logic live
);
    typedef enum logic {SLOT_OPEN, SLOT_CLEARED} slot_st_e;

    slot_st_e cur_st;
    slot_st_e nxt_st;

    always_ff @(posedge clk) begin
        if (!rst_n) cur_st <= SLOT_OPEN;
        else        cur_st <= nxt_st;
    end

    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            SLOT_OPEN:    if (grant_fence) nxt_st = SLOT_CLEARED;
            SLOT_CLEARED: if (!valid)      nxt_st = SLOT_OPEN;
            default:      nxt_st = SLOT_OPEN;
        endcase
    end

    always_comb begin
        live = valid && (cur_st == SLOT_OPEN);
    end
endmodule

// File: rtl/gate_slot_classify.sv
module gate_slot_classify
    import fence_gate_pkg::*;
(
    input  logic               live,
    input  logic               done,
    input  logic [KIND_W-1:0]  kind,
    input  logic [ANNOT_W-1:0] annot,
    input  logic [FBITS_W-1:0] fbits,
    output blk_t               blk
);
    logic pend;
    logic is_ld;
    logic is_st;

    always_comb begin
        pend  = live && !done;
        is_ld = pend && (kind == K_LOAD);
        is_st = pend && (kind == K_STORE);
        blk.ld      = is_ld;
        blk.st      = is_st;
        blk.any     = pend && (kind inside {K_LOAD, K_STORE, K_FENCE, K_TSO, K_BRANCH});
        blk.f_sw    = pend && (kind == K_FENCE) && fbits[FB_NEW_ST];
        blk.tso     = pend && (kind == K_TSO);
        blk.acq_ld  = is_ld && (annot inside {A_ACQ_PC, A_ACQ_SC, A_AQRL});
        blk.aqrl_st = is_st && (annot == A_AQRL);
        blk.br      = pend && (kind == K_BRANCH);
        blk.pw_sr   = pend && (kind == K_FENCE) && fbits[FB_OLD_ST] && fbits[FB_NEW_LD];
        blk.rcsc_rl = is_st && (annot inside {A_REL_SC, A_AQRL});
    end
endmodule

// File: rtl/gate_slot_decide.sv
module gate_slot_decide
    import fence_gate_pkg::*;
(
    input  logic               live,
    input  logic               done,
    input  logic [KIND_W-1:0]  kind,
    input  logic [ANNOT_W-1:0] annot,
    input  logic [FBITS_W-1:0] fbits,
    input  blk_t               older,
    output logic               permit,
    output logic               illegal
);
    logic pend;
    logic ok_fence;
    logic ok_tso;
    logic ok_store;
    logic ok_load;

    always_comb begin
        pend     = live && !done;
        illegal  = pend && (kind == K_FENCE) && !fbits_legal(fbits);
        ok_fence = fbits_legal(fbits)
                 && !(fbits[FB_OLD_LD] && older.ld)
                 && !(fbits[FB_OLD_ST] && older.st);
        ok_tso   = !older.ld && !older.st;
        ok_store = !older.f_sw && !older.tso && !older.acq_ld && !older.aqrl_st && !older.br
                 && !((annot inside {A_REL_PC, A_REL_SC, A_AQRL}) && older.any);
        ok_load  = !older.pw_sr
                 && !((annot == A_AQRL) && older.any)
                 && !((annot == A_ACQ_SC) && older.rcsc_rl);
        permit = 1'b0;
        if (pend) begin
            unique case (kind)
                K_FENCE: permit = ok_fence;
                K_TSO:   permit = ok_tso;
                K_STORE: permit = ok_store;
                K_LOAD:  permit = ok_load;
                default: permit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fence_order_gate.sv
module fence_order_gate
    import fence_gate_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         slot_valid,
    input  logic [N-1:0]         slot_done,
    input  logic [N*KIND_W-1:0]  slot_kind,
    input  logic [N*ANNOT_W-1:0] slot_annot,
    input  logic [N*FBITS_W-1:0] slot_fbits,
    output logic [N-1:0]         permit,
    output logic [N-1:0]         fence_illegal
);
    localparam int BLK_W = $bits(blk_t);

    logic [N-1:0] live;
    blk_t         own   [N];
    blk_t         older [N];

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic [KIND_W-1:0] kind_i;
        logic              grant_i;

        assign kind_i  = slot_kind[i*KIND_W +: KIND_W];
        assign grant_i = permit[i] && (kind_i inside {K_FENCE, K_TSO});

        gate_slot_fsm i_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .valid       (slot_valid[i]),
            .grant_fence (grant_i),
            .live        (live[i])
        );

        gate_slot_classify i_cls (
            .live  (live[i]),
            .done  (slot_done[i]),
            .kind  (kind_i),
            .annot (slot_annot[i*ANNOT_W +: ANNOT_W]),
            .fbits (slot_fbits[i*FBITS_W +: FBITS_W]),
            .blk   (own[i])
        );

        if (i == 0) begin : g_head
            assign older[i] = blk_t'({BLK_W{1'b0}});
        end else begin : g_tail
            assign older[i] = blk_t'(older[i-1] | own[i-1]);
        end

        gate_slot_decide i_dec (
            .live    (live[i]),
            .done    (slot_done[i]),
            .kind    (kind_i),
            .annot   (slot_annot[i*ANNOT_W +: ANNOT_W]),
            .fbits   (slot_fbits[i*FBITS_W +: FBITS_W]),
            .older   (older[i]),
            .permit  (permit[i]),
            .illegal (fence_illegal[i])
        );
    end
endmodule

// File: rtl/fence_order_gate_chk.sv
module fence_order_gate_chk
    import fence_gate_pkg::*;
#(
    parameter int N = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N-1:0]         slot_valid,
    input logic [N-1:0]         slot_done,
    input logic [N*KIND_W-1:0]  slot_kind,
    input logic [N-1:0]         permit,
    input logic [N-1:0]         fence_illegal
);
    for (genvar i = 0; i < N; i++) begin : g_chk
        logic [KIND_W-1:0] k;
        assign k = slot_kind[i*KIND_W +: KIND_W];

        // R8: a granted fence is cleared at the next edge
        a_r8_fence_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (permit[i] && (k == K_FENCE || k == K_TSO)) |=> !permit[i]);

        // R7: an illegal fence never proceeds
        a_r7_illegal_held: assert property (@(posedge clk) disable iff (!rst_n)
            fence_illegal[i] |-> !permit[i]);

        // R9: idle, finished, empty and branch slots never proceed
        a_r9_idle_no_permit: assert property (@(posedge clk) disable iff (!rst_n)
            (!slot_valid[i] || slot_done[i] || k == K_BRANCH || k == K_EMPTY) |-> !permit[i]);
    end

    // R9: a fresh load or store at the head is always free
    a_r9_head_free: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid[0] && !slot_done[0] && !$past(slot_valid[0]) &&
         (slot_kind[KIND_W-1:0] == K_LOAD || slot_kind[KIND_W-1:0] == K_STORE))
        |-> permit[0]);
endmodule

bind fence_order_gate fence_order_gate_chk #(.N(N)) i_fence_order_gate_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .slot_valid    (slot_valid),
    .slot_done     (slot_done),
    .slot_kind     (slot_kind),
    .permit        (permit),
    .fence_illegal (fence_illegal)
);

// File: tb/test_fence_order_gate.sv
module test_fence_order_gate;
    localparam int N = 8;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     slot_valid = '0;
    logic [N-1:0]     slot_done = '0;
    logic [N*3-1:0]   slot_kind = '0;
    logic [N*3-1:0]   slot_annot = '0;
    logic [N*4-1:0]   slot_fbits = '0;
    logic [N-1:0]     permit;
    logic [N-1:0]     fence_illegal;

    int errors = 0;
    int checks = 0;
    logic [N-1:0] mdl_clr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fence_order_gate #(.N(N)) i_fence_order_gate (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_done(slot_done),
        .slot_kind(slot_kind), .slot_annot(slot_annot), .slot_fbits(slot_fbits),
        .permit(permit), .fence_illegal(fence_illegal)
    );

    function automatic logic legal_bits(input logic [3:0] b);
        return b == 4'b1010 || b == 4'b0101 || b == 4'b1101 || b == 4'b1011 || b == 4'b1111;
    endfunction

    function automatic logic [2:0] kd(input int i);
        return slot_kind[i*3 +: 3];
    endfunction
    function automatic logic [2:0] an(input int i);
        return slot_annot[i*3 +: 3];
    endfunction
    function automatic logic [3:0] fb(input int i);
        return slot_fbits[i*4 +: 4];
    endfunction
    function automatic logic pend(input int i);
        return slot_valid[i] && !mdl_clr[i] && !slot_done[i];
    endfunction

    // expected permits from requirement text (R1-style rules per kind)
    function automatic logic [N-1:0] exp_permit();
        logic [N-1:0] r = '0;
        for (int i = 0; i < N; i++) begin
            logic ok = 1'b1;
            if (!pend(i)) continue;
            for (int j = 0; j < i; j++) begin
                logic [2:0] kj = kd(j);
                logic [2:0] aj = an(j);
                logic [3:0] fj = fb(j);
                if (!pend(j)) continue;
                case (kd(i))
                    3'd3: begin
                        if (fb(i)[3] && kj == 3'd1) ok = 0;
                        if (fb(i)[2] && kj == 3'd2) ok = 0;
                    end
                    3'd4: if (kj == 3'd1 || kj == 3'd2) ok = 0;
                    3'd2: begin
                        if (kj == 3'd3 && fj[0]) ok = 0;
                        if (kj == 3'd4 || kj == 3'd5) ok = 0;
                        if (kj == 3'd1 && (aj == 1 || aj == 2 || aj == 5)) ok = 0;
                        if (kj == 3'd2 && aj == 5) ok = 0;
                        if ((an(i) == 3 || an(i) == 4 || an(i) == 5) && kj >= 1 && kj <= 5) ok = 0;
                    end
                    3'd1: begin
                        if (kj == 3'd3 && fj[2] && fj[1]) ok = 0;
                        if (an(i) == 5 && kj >= 1 && kj <= 5) ok = 0;
                        if (an(i) == 2 && kj == 3'd2 && (aj == 4 || aj == 5)) ok = 0;
                    end
                    default: ok = 0;
                endcase
            end
            if (kd(i) == 3'd3 && !legal_bits(fb(i))) ok = 0;
            if (!(kd(i) inside {3'd1, 3'd2, 3'd3, 3'd4})) ok = 0;
            r[i] = ok;
        end
        return r;
    endfunction

    function automatic logic [N-1:0] exp_illegal();
        logic [N-1:0] r = '0;
        for (int i = 0; i < N; i++)
            r[i] = pend(i) && kd(i) == 3'd3 && !legal_bits(fb(i));
        return r;
    endfunction

    task automatic check_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // check at mid-cycle, advance the model across one rising edge
    task automatic run(input string tag);
        logic [N-1:0] ep;
        logic [N-1:0] nxt;
        #1;
        ep = exp_permit();
        check_vec({tag, " permit"}, permit, ep);
        check_vec({tag, " illegal"}, fence_illegal, exp_illegal());
        nxt = mdl_clr;
        for (int i = 0; i < N; i++) begin
            if (!mdl_clr[i] && ep[i] && (kd(i) == 3'd3 || kd(i) == 3'd4)) nxt[i] = 1'b1;
            else if (mdl_clr[i] && !slot_valid[i]) nxt[i] = 1'b0;
        end
        if (!rst_n) nxt = '0;
        @(posedge clk);
        mdl_clr = nxt;
        @(negedge clk);
    endtask

    task automatic set_slot(input int i, input logic v, input logic [2:0] k,
                            input logic [2:0] a, input logic [3:0] f, input logic d);
        slot_valid[i] = v;
        slot_kind[i*3 +: 3] = k;
        slot_annot[i*3 +: 3] = a;
        slot_fbits[i*4 +: 4] = f;
        slot_done[i] = d;
    endtask

    task automatic wipe();
        slot_valid = '0; slot_done = '0; slot_kind = '0; slot_annot = '0; slot_fbits = '0;
        run("wipe");
        run("wipe");
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R10: fence granted during reset is not cleared
        set_slot(0, 1, 3'd3, 3'd0, 4'b1010, 0);
        run("R10 in reset");
        run("R10 in reset");
        rst_n = 1'b1;
        run("R10 after reset");
        run("R8 cleared");
        wipe();

        // R1
        set_slot(0, 1, 3'd1, 0, 0, 0);
        set_slot(1, 1, 3'd3, 0, 4'b1010, 0);
        run("R1 pr waits load");
        wipe();
        set_slot(0, 1, 3'd2, 0, 0, 0);
        set_slot(1, 1, 3'd3, 0, 4'b1010, 0);
        run("R1 pr ignores store");
        wipe();
        set_slot(0, 1, 3'd2, 0, 0, 0);
        set_slot(1, 1, 3'd3, 0, 4'b0101, 0);
        run("R1 pw waits store");
        wipe();

        // R2
        set_slot(0, 1, 3'd2, 0, 0, 0);
        set_slot(1, 1, 3'd4, 0, 0, 0);
        run("R2 tso blocked");
        slot_done[0] = 1'b1;
        run("R2 tso free");
        wipe();

        // R3
        set_slot(0, 1, 3'd5, 0, 0, 0);
        set_slot(1, 1, 3'd2, 0, 0, 0);
        run("R3 branch blocks store");
        set_slot(0, 1, 3'd1, 3'd1, 0, 0);
        run("R3 acquire load blocks store");
        set_slot(0, 1, 3'd1, 3'd0, 0, 0);
        run("R3 plain load allows store");
        wipe();

        // R4
        set_slot(0, 1, 3'd1, 0, 0, 0);
        set_slot(1, 1, 3'd2, 3'd3, 0, 0);
        run("R4 release store waits");
        wipe();

        // R5 and R8: fence 1111 holds a load until it clears
        set_slot(0, 1, 3'd3, 0, 4'b1111, 0);
        set_slot(1, 1, 3'd1, 0, 0, 0);
        set_slot(2, 1, 3'd2, 0, 0, 0);
        run("R5 load behind pw_sr");
        run("R8 cleared frees load");
        run("R8 stays cleared");
        slot_valid[0] = 1'b0;
        run("R8 valid low");
        slot_valid[0] = 1'b1;
        run("R8 reopened");
        wipe();

        // R6
        set_slot(0, 1, 3'd2, 3'd4, 0, 0);
        set_slot(1, 1, 3'd1, 3'd2, 0, 0);
        set_slot(2, 1, 3'd1, 3'd1, 0, 0);
        set_slot(3, 1, 3'd1, 3'd5, 0, 0);
        run("R6 acquire loads");
        wipe();

        // R7
        set_slot(0, 1, 3'd3, 0, 4'b0011, 0);
        set_slot(1, 1, 3'd3, 0, 4'b0110, 0);
        run("R7 illegal bits");
        wipe();

        // R9
        set_slot(0, 1, 3'd5, 0, 0, 0);
        set_slot(1, 1, 3'd1, 0, 0, 1);
        set_slot(2, 0, 3'd2, 0, 0, 0);
        set_slot(3, 1, 3'd0, 0, 0, 0);
        run("R9 idle slots");
        wipe();

        // random mix
        begin
            int unsigned s;
            logic [3:0] lf [6] = '{4'b1010, 4'b0101, 4'b1101, 4'b1011, 4'b1111, 4'b1111};
            s = $urandom(32'h5eed);
            for (int c = 0; c < 3000; c++) begin
                for (int i = 0; i < N; i++) begin
                    logic [3:0] f;
                    f = ($urandom_range(0, 15) == 0) ? 4'($urandom_range(0, 15))
                                                     : lf[$urandom_range(0, 5)];
                    set_slot(i, $urandom_range(0, 3) != 0, 3'($urandom_range(0, 6)),
                             3'($urandom_range(0, 6)), f, $urandom_range(0, 3) == 0);
                end
                run("RAND R1 R3 R8");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule